// File: doc/BRIEF.md
# Start-of-Frame Lock Detector

This block sits behind a subcarrier correlator and watches its stream of signed soft decisions, which arrive at two samples per bit period (ETU). It finds a valid start-of-frame from a tag: a stretch of carrier, then a low phase of bounded length, then a short high phase that ends with the first start bit. Each phase is timed in samples against its own window. When the first start bit arrives, the block gives a one-cycle hand-off pulse to the character receiver that follows it. It then stays locked until it is reset.

The windows are wider than the nominal start-of-frame timing, so that edges smeared by the analogue front end are still accepted. The minimum low phase is shortened, the maximum low phase is lengthened, and the high phase before the start bit is kept short. Any phase that falls outside its window sends the block back to the unsynchronized state and raises a one-cycle loss indication. A positive soft decision is a logic 1. A zero or negative soft decision is a logic 0.

Top module: `sof_sync`

## Requirements
- R1: After reset, sync_state is 0 (unsynchronized), and sof_found, start_bit_seen and sync_lost are all 0.
- R2: While unsynchronized, zero and negative samples are ignored. A positive sample moves sync_state to 1 (carrier wait), and that sample counts as the first sample of the phase.
- R3: In state 1, a non-positive sample moves sync_state to 2 (low phase), and that sample counts as the first low sample. The 53rd positive sample in state 1 (the entering sample included) returns the block to 0.
- R4: In state 2, a positive sample that arrives after fewer than 16 low samples returns the block to 0.
- R5: In state 2, a positive sample after 16 or more low samples moves sync_state to 3 (high phase) and sets sof_found to 1 in the same cycle. That positive sample counts as the first high sample.
- R6: In state 2, the 29th low sample returns the block to 0.
- R7: In state 3, the 5th positive sample returns the block to 0 and clears sof_found.
- R8: In state 3, a non-positive sample (the start bit) sets start_bit_seen for exactly one cycle and moves sync_state to 4 (locked). From then on, sync_state stays 4 and sof_found stays 1 whatever the samples are, until reset.
- R9: A sample of value zero is classed as low, in the same way as a negative sample.
- R10: A cycle with sample_valid low changes neither the state nor the phase sample count, whatever the value on sample.
- R11: sync_lost is a one-cycle pulse. It is raised only in the cycle in which a window violation returns the block to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies sample for this cycle |
| sample | input | SAMPLE_W | Signed soft decision from the correlator |
| sync_state | output | 3 | 0 unsynchronized, 1 carrier wait, 2 low phase, 3 high phase, 4 locked |
| sof_found | output | 1 | Start-of-frame accepted; held while in state 3 or 4 |
| start_bit_seen | output | 1 | One-cycle hand-off pulse on the first start bit |
| sync_lost | output | 1 | One-cycle pulse on a window violation |

## Verification
sync_state is registered and brought out at the port, so a wrong state transition shows on the cycle after the sample that caused it. A phase count that is off by even one sample moves the point at which a window closes. The tests therefore place the deciding sample exactly on each limit and one sample beyond it: 16 and 15 low samples, 28 and 29 low samples, 52 and 53 carrier samples, and 4 and 5 high samples. Idle cycles are inserted in the middle of a phase to show that the count does not drift. Stray pulses on sof_found, start_bit_seen and sync_lost are visible on the cycle after the sample that caused them.

// File: rtl/sof_sync_pkg.sv
package sof_sync_pkg;

    typedef enum logic [2:0] {
        ST_UNSYNC    = 3'd0,
        ST_WAIT_FALL = 3'd1,
        ST_LOW       = 3'd2,
        ST_HIGH      = 3'd3,
        ST_LOCKED    = 3'd4
    } sync_state_e;

    typedef enum logic [1:0] {
        V_STAY,
        V_ADVANCE,
        V_LOSE
    } verdict_e;

    function automatic sync_state_e next_phase(input sync_state_e s);
        case (s)
            ST_UNSYNC:    return ST_WAIT_FALL;
            ST_WAIT_FALL: return ST_LOW;
            ST_LOW:       return ST_HIGH;
            ST_HIGH:      return ST_LOCKED;
            default:      return ST_LOCKED;
        endcase
    endfunction

    function automatic logic is_counting(input sync_state_e s);
        return (s == ST_WAIT_FALL) || (s == ST_LOW) || (s == ST_HIGH);
    endfunction

endpackage

// File: rtl/sof_slicer.sv
module sof_slicer #(
    parameter int SAMPLE_W = 8
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       bit_hi
);
    // Strictly positive means logic 1; zero joins the negative side.
    always_comb bit_hi = (sample > $signed({SAMPLE_W{1'b0}}));
endmodule

// File: rtl/sof_window.sv
module sof_window
    import sof_sync_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int WAIT_MAX = 52,
    parameter int LOW_MIN  = 16,
    parameter int LOW_MAX  = 28,
    parameter int HIGH_MAX = 4
) (
    input  sync_state_e      state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             bit_hi,
    output verdict_e         verdict
);
    // cnt holds samples already seen in the phase; one more than a
    // maximum is reached when cnt is already equal to it.
    always_comb begin
        verdict = V_STAY;
        case (state)
            ST_UNSYNC:
                if (bit_hi) verdict = V_ADVANCE;
            ST_WAIT_FALL:
                if (!bit_hi)                          verdict = V_ADVANCE;
                else if (cnt >= CNT_W'(WAIT_MAX))     verdict = V_LOSE;
            ST_LOW:
                if (bit_hi)
                    verdict = (cnt < CNT_W'(LOW_MIN)) ? V_LOSE : V_ADVANCE;
                else if (cnt >= CNT_W'(LOW_MAX))      verdict = V_LOSE;
            ST_HIGH:
                if (!bit_hi)                          verdict = V_ADVANCE;
                else if (cnt >= CNT_W'(HIGH_MAX))     verdict = V_LOSE;
            default:
                verdict = V_STAY;
        endcase
    end
endmodule

// File: rtl/sof_sync.sv
module sof_sync
    import sof_sync_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int WAIT_MAX = 52,
    parameter int LOW_MIN  = 16,
    parameter int LOW_MAX  = 28,
    parameter int HIGH_MAX = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic [2:0]                 sync_state,
    output logic                       sof_found,
    output logic                       start_bit_seen,
    output logic                       sync_lost
);
    localparam int LIM_A  = (WAIT_MAX > LOW_MAX) ? WAIT_MAX : LOW_MAX;
    localparam int LIM_TOP = (LIM_A > HIGH_MAX) ? LIM_A : HIGH_MAX;
    localparam int CNT_W  = $clog2(LIM_TOP + 2);

    sync_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             bit_hi;
    verdict_e         verdict;

    sof_slicer #(.SAMPLE_W(SAMPLE_W)) u_slicer (
        .sample (sample),
        .bit_hi (bit_hi)
    );

    sof_window #(
        .CNT_W(CNT_W), .WAIT_MAX(WAIT_MAX), .LOW_MIN(LOW_MIN),
        .LOW_MAX(LOW_MAX), .HIGH_MAX(HIGH_MAX)
    ) u_window (
        .state   (state),
        .cnt     (cnt),
        .bit_hi  (bit_hi),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_UNSYNC;
            cnt            <= '0;
            sof_found      <= 1'b0;
            start_bit_seen <= 1'b0;
            sync_lost      <= 1'b0;
        end else begin
            start_bit_seen <= 1'b0;
            sync_lost      <= 1'b0;
            if (sample_valid) begin
                case (verdict)
                    V_ADVANCE: begin
                        state <= next_phase(state);
                        // The sample that opens a timed phase is its first.
                        cnt   <= (state == ST_HIGH) ? '0 : CNT_W'(1);
                        if (state == ST_LOW)  sof_found      <= 1'b1;
                        if (state == ST_HIGH) start_bit_seen <= 1'b1;
                    end
                    V_LOSE: begin
                        state     <= ST_UNSYNC;
                        cnt       <= '0;
                        sof_found <= 1'b0;
                        sync_lost <= 1'b1;
                    end
                    default: begin
                        if (is_counting(state)) cnt <= cnt + 1'b1;
                    end
                endcase
            end
        end
    end

    assign sync_state = state;

    a_r3_wait_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_WAIT_FALL |-> cnt <= CNT_W'(WAIT_MAX));
    a_r6_low_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOW |-> cnt <= CNT_W'(LOW_MAX));
    a_r7_high_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_HIGH |-> cnt <= CNT_W'(HIGH_MAX));
    a_r5_found_only_after_low: assert property (@(posedge clk) disable iff (rst)
        sof_found |-> (state == ST_HIGH || state == ST_LOCKED));
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        start_bit_seen |=> !start_bit_seen);
    a_r8_locked_holds: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOCKED |=> (state == ST_LOCKED && sof_found));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(state) && $stable(cnt)));
    a_r11_lost_unsync: assert property (@(posedge clk) disable iff (rst)
        sync_lost |-> (state == ST_UNSYNC && !sof_found));
    a_r11_lost_single: assert property (@(posedge clk) disable iff (rst)
        sync_lost |=> !sync_lost);

endmodule

// File: tb/sim_sof_sync.sv
module sim_sof_sync;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_valid = 1'b0;
    logic signed [7:0] sample = '0;
    logic [2:0]        sync_state;
    logic              sof_found, start_bit_seen, sync_lost;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sof_sync u0 (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
        .sync_state(sync_state), .sof_found(sof_found),
        .start_bit_seen(start_bit_seen), .sync_lost(sync_lost)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; sample_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // One valid sample; outputs are read at the following falling edge.
    task automatic push(input int s);
        @(negedge clk); sample = 8'(s); sample_valid = 1'b1;
        @(negedge clk); sample_valid = 1'b0;
    endtask

    task automatic push_n(input int s, input int n);
        for (int i = 0; i < n; i++) push(s);
    endtask

    task automatic idle(input int n, input int junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sample = 8'(junk); sample_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", sync_state, 0);
        check("R1 sof_found", sof_found, 0);
        check("R1 start_bit_seen", start_bit_seen, 0);
        check("R1 sync_lost", sync_lost, 0);
    endtask

    task automatic t_unsync_ignore();
        do_reset();
        push(-5); push(0);
        check("R2 nonpositive ignored", sync_state, 0);
        idle(4, 100);
        check("R10 invalid positive ignored", sync_state, 0);
        push(3);
        check("R2 positive leaves unsync", sync_state, 1);
    endtask

    task automatic t_good_frame();
        do_reset();
        push_n(20, 11);
        check("R3 carrier wait", sync_state, 1);
        push(0);
        check("R9 zero is low", sync_state, 2);
        push_n(-30, 7);
        idle(5, 90);
        check("R10 idle in low", sync_state, 2);
        push_n(-30, 8);
        push(40);
        check("R5 16 lows accepted", sync_state, 3);
        check("R5 sof_found", sof_found, 1);
        push_n(40, 3);
        check("R7 4 highs kept", sync_state, 3);
        push(-1);
        check("R8 start pulse", start_bit_seen, 1);
        check("R8 locked", sync_state, 4);
        push(50);
        check("R8 pulse one cycle", start_bit_seen, 0);
        push_n(-50, 60);
        check("R8 stays locked", sync_state, 4);
        check("R8 found held", sof_found, 1);
        check("R11 no loss when locked", sync_lost, 0);
    endtask

    task automatic t_short_low();
        do_reset();
        push(5); push_n(-5, 15); push(5);
        check("R4 15 lows rejected", sync_state, 0);
        check("R11 loss pulse", sync_lost, 1);
        check("R4 no sof", sof_found, 0);
        push(-5);
        check("R11 loss one cycle", sync_lost, 0);
    endtask

    task automatic t_long_low();
        do_reset();
        push(5); push_n(-5, 14);
        idle(3, 7);
        push_n(-5, 14);
        check("R6 28 lows kept", sync_state, 2);
        check("R11 no false loss", sync_lost, 0);
        push(-5);
        check("R6 29th low drops", sync_state, 0);
        check("R6 loss pulse", sync_lost, 1);
    endtask

    task automatic t_wait_timeout();
        do_reset();
        push_n(9, 52);
        check("R3 52 carrier kept", sync_state, 1);
        push(9);
        check("R3 53rd drops", sync_state, 0);
        check("R3 loss pulse", sync_lost, 1);
    endtask

    task automatic t_high_timeout();
        do_reset();
        push(5); push_n(-5, 16); push(5);
        check("R5 entered high", sync_state, 3);
        push_n(5, 3);
        check("R7 4th high kept", sync_state, 3);
        push(5);
        check("R7 5th high drops", sync_state, 0);
        check("R7 found cleared", sof_found, 0);
        check("R7 loss pulse", sync_lost, 1);
        check("R8 no start pulse", start_bit_seen, 0);
    endtask

    initial begin
        t_reset();
        t_unsync_ignore();
        t_good_frame();
        t_short_low();
        t_long_low();
        t_wait_timeout();
        t_high_timeout();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule